// File: doc/BRIEF.md
# Synchronous Serial Absolute Encoder Master

This block reads position frames from absolute encoders over a synchronous serial link. It has one or more channels. Each channel drives its own serial clock and samples its own data line. A channel runs a frame when one of two things happens: a write to the shared start register while the channel's global-start enable is set, or a strobe on the one of several timer lines that the channel has selected. Each channel sets its bit rate with a 16-bit fractional increment, and the frame length is programmable from 1 to 64 bits.

A host drives the block over a simple 32-bit register bus. The bus has write-enable, address and write data, and returns read data combinationally from the address. Each channel has a control register, a low data word and a high data word. The shared register starts frames when it is written and returns the per-channel busy flags when it is read. After the last bit, a channel holds its clock high for a fixed quiet time before it reports idle, so the encoder can re-arm.

Register map, with `n` the channel number: `4n+0` is the data low word, `4n+1` is the data high word, `4n+2` is control, and address `4*NUM_CH` is the shared start/busy register.

Top module: `ssi_master`

## Requirements
- R1: After reset, every control register reads `DEF_INC << 16`, where DEF_INC = floor(65536 × DEF_RATE_HZ / CLK_HZ). That value is 163 (0x00A30000) at the defaults. Data words read 0, the busy register reads 0 and every serial clock is high.
- R2: The control register keeps bits 31:16 (rate increment), 14:12 (timer select), 9 (timer enable), 8 (global-start enable) and 6:0 (bit count). It reads back the last value written, masked with 0xFFFF737F.
- R3: Writing any value to the shared register starts every idle channel whose bit 8 is set. A channel with bit 8 clear stays idle.
- R4: A channel with bit 9 set starts when the strobe line numbered by its timer-select field pulses. Strobes on other lines, and select values at or above the number of timers, start nothing.
- R5: Reading the shared register returns channel n's busy flag at bit n. The flag is set from the clock edge that accepts the start and stays set until the quiet time ends.
- R6: A 16-bit phase accumulator, cleared while the channel is idle, adds the increment on every clock. Each carry toggles the serial clock. With increment 0x8000, the clock falls 2 edges after the start edge and rises 2 edges after that. The clock is high whenever the channel is idle.
- R7: Data is sampled on each rising serial clock edge and shifted in MSB first. At the end of a frame of N bits, the received value is right-aligned in 64 bits, with bits 31:0 in the low word and bits 63:32 in the high word. A bit count above 64 acts as 64, and a count of 0 starts no frame.
- R8: A frame of N bits has exactly N falling and N rising serial clock edges.
- R9: Busy clears exactly MONO_CYCLES clock edges after the edge on which the last bit is sampled.
- R10: A start request, global or timer, that arrives while the channel is busy is ignored and does not lengthen the frame.
- R11: Bus writes to data word addresses have no effect. Data words change only at the end of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| timer_strobe_i | input | NUM_TIMERS | Single-cycle timer strobes |
| ssi_clk_o | output | NUM_CH | Serial clock per channel, idle high |
| ssi_data_i | input | NUM_CH | Serial data per channel |

## Verification
A start is accepted on the clock edge that sees the write or the strobe, so the busy bit is read at the falling clock edge right after it. With increment 0x8000, the serial clock is sampled at each of the next four falling edges and must read high, low, low, high. The bench completes each frame by polling busy at every falling clock edge and counting serial clock transitions between samples. It records the sample index of the last rise, so the quiet time is checked as an exact difference of MONO_CYCLES. A behavioural encoder changes its data line on each falling serial clock. Data words are read only after busy has cleared.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  localparam int ACC_W      = 16;
  localparam int NB_W       = 7;
  localparam int MAX_BITS   = 64;
  localparam int TSEL_LSB   = 12;
  localparam int TSEL_W     = 3;
  localparam int GEN_BIT    = 8;
  localparam int TEN_BIT    = 9;
  localparam int INC_LSB    = 16;
  localparam int CH_SPAN    = 4;
  localparam int REG_LO     = 0;
  localparam int REG_HI     = 1;
  localparam int REG_CTRL   = 2;
  localparam logic [31:0] CTRL_MASK = 32'hFFFF_737F;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} ch_state_e;
endpackage

// File: rtl/ssi_phase_acc.sv
module ssi_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, inc_i};
  assign tick_o = run_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (run_i)  acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ssi_chan.sv
module ssi_chan
  import ssi_pkg::*;
#(
  parameter int MONO_CYCLES = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [ACC_W-1:0]    inc_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic                sdata_i,
  output logic                sclk_o,
  output logic                busy_o,
  output logic [MAX_BITS-1:0] word_o
);
  localparam int GAP_W = $clog2(MONO_CYCLES + 1);

  ch_state_e           state_q;
  logic [NB_W-1:0]     left_q;
  logic [NB_W-1:0]     nb_eff;
  logic [MAX_BITS-1:0] sr_q;
  logic [MAX_BITS-1:0] sr_nx;
  logic [GAP_W-1:0]    gap_q;
  logic                tick;

  assign nb_eff = (nbits_i > NB_W'(MAX_BITS)) ? NB_W'(MAX_BITS) : nbits_i;
  assign sr_nx  = {sr_q[MAX_BITS-2:0], sdata_i};
  assign busy_o = (state_q != ST_IDLE);

  ssi_phase_acc #(.ACC_W(ACC_W)) i_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .run_i  (state_q == ST_SHIFT),
    .inc_i  (inc_i),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_o  <= 1'b1;
      left_q  <= '0;
      sr_q    <= '0;
      word_o  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sclk_o <= 1'b1;
          if (start_i && nb_eff != '0) begin
            state_q <= ST_SHIFT;
            left_q  <= nb_eff;
            sr_q    <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (sclk_o) begin
              sclk_o <= 1'b0;
            end else begin
              // rising edge: sample
              sclk_o <= 1'b1;
              sr_q   <= sr_nx;
              left_q <= left_q - 1'b1;
              if (left_q == NB_W'(1)) begin
                word_o  <= sr_nx;
                state_q <= ST_GAP;
                gap_q   <= '0;
              end
            end
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(MONO_CYCLES - 1)) state_q <= ST_IDLE;
          else                                  gap_q   <= gap_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ssi_master.sv
module ssi_master
  import ssi_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int NUM_TIMERS  = 5,
  parameter int CLK_HZ      = 200_000_000,
  parameter int DEF_RATE_HZ = 500_000,
  parameter int MONO_CYCLES = 40,
  localparam int AW         = $clog2(NUM_CH * CH_SPAN + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic [AW-1:0]         reg_addr_i,
  input  logic [31:0]           reg_wdata_i,
  output logic [31:0]           reg_rdata_o,
  input  logic [NUM_TIMERS-1:0] timer_strobe_i,
  output logic [NUM_CH-1:0]     ssi_clk_o,
  input  logic [NUM_CH-1:0]     ssi_data_i
);
  localparam int          GLOBAL_ADDR = NUM_CH * CH_SPAN;
  localparam logic [63:0] DEF_INC     = (64'd65536 * 64'(DEF_RATE_HZ)) / 64'(CLK_HZ);
  localparam logic [31:0] CTRL_RST    = {DEF_INC[15:0], 16'h0000};

  logic                          glob_wr;
  logic [NUM_CH-1:0]             busy_w;
  logic [31:0]                   ctrl_w [NUM_CH];
  logic [MAX_BITS-1:0]           word_w [NUM_CH];
  logic [NUM_CH*32-1:0]          ctrl_flat;
  logic [NUM_CH*MAX_BITS-1:0]    word_flat;

  assign glob_wr = reg_we_i && (reg_addr_i == AW'(GLOBAL_ADDR));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [31:0]       ctrl_q;
    logic              tim_hit;
    logic              start;
    logic [TSEL_W-1:0] tsel;

    assign tsel = ctrl_q[TSEL_LSB +: TSEL_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q <= CTRL_RST;
      else if (reg_we_i && reg_addr_i == AW'(ch * CH_SPAN + REG_CTRL))
        ctrl_q <= reg_wdata_i & CTRL_MASK;
    end

    always_comb begin
      tim_hit = 1'b0;
      for (int t = 0; t < NUM_TIMERS; t++)
        if (tsel == TSEL_W'(t)) tim_hit = timer_strobe_i[t];
    end

    assign start = (glob_wr & ctrl_q[GEN_BIT]) | (ctrl_q[TEN_BIT] & tim_hit);

    ssi_chan #(.MONO_CYCLES(MONO_CYCLES)) i_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .inc_i   (ctrl_q[INC_LSB +: ACC_W]),
      .nbits_i (ctrl_q[NB_W-1:0]),
      .sdata_i (ssi_data_i[ch]),
      .sclk_o  (ssi_clk_o[ch]),
      .busy_o  (busy_w[ch]),
      .word_o  (word_w[ch])
    );

    assign ctrl_w[ch]                         = ctrl_q;
    assign ctrl_flat[ch*32 +: 32]             = ctrl_q;
    assign word_flat[ch*MAX_BITS +: MAX_BITS] = word_w[ch];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == AW'(GLOBAL_ADDR)) reg_rdata_o = 32'(busy_w);
    for (int c = 0; c < NUM_CH; c++) begin
      if (reg_addr_i == AW'(c * CH_SPAN + REG_LO))   reg_rdata_o = word_w[c][31:0];
      if (reg_addr_i == AW'(c * CH_SPAN + REG_HI))   reg_rdata_o = word_w[c][63:32];
      if (reg_addr_i == AW'(c * CH_SPAN + REG_CTRL)) reg_rdata_o = ctrl_w[c];
    end
  end
endmodule

// File: rtl/ssi_master_chk.sv
module ssi_master_chk
  import ssi_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int AW     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       reg_we_i,
  input logic [AW-1:0]              reg_addr_i,
  input logic [31:0]                reg_wdata_i,
  input logic [NUM_CH-1:0]          busy_i,
  input logic [NUM_CH-1:0]          sclk_i,
  input logic [NUM_CH*32-1:0]       ctrl_i,
  input logic [NUM_CH*MAX_BITS-1:0] word_i
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R6
    idle_clk_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i[c] |-> sclk_i[c]);

    // R8
    clk_moves_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(sclk_i[c]) |-> $past(busy_i[c]));

    // R11
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(word_i[c*MAX_BITS +: MAX_BITS]) |-> $past(busy_i[c]));

    // R2
    ctrl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_we_i && reg_addr_i == AW'(c * CH_SPAN + REG_CTRL))
      |=> ctrl_i[c*32 +: 32] == ($past(reg_wdata_i) & CTRL_MASK));
  end
endmodule

bind ssi_master ssi_master_chk #(.NUM_CH(NUM_CH), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .busy_i      (busy_w),
  .sclk_i      (ssi_clk_o),
  .ctrl_i      (ctrl_flat),
  .word_i      (word_flat)
);

// File: tb/test_ssi_master.sv
`timescale 1ns/1ps
module test_ssi_master;
  localparam int GADDR = 8;
  localparam int MONO  = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [4:0]  tstb = '0;
  logic [1:0]  sclk;
  logic        sdat0 = 1'b0;
  logic        sdat1 = 1'b0;
  logic [1:0]  sdat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [63:0] enc_word0 = '0, enc_word1 = '0;
  int          enc_idx0 = -1, enc_idx1 = -1;

  assign sdat = {sdat1, sdat0};

  always #2.5 clk = ~clk;

  ssi_master #(.MONO_CYCLES(MONO)) i_ssi_master (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .reg_we_i       (we),
    .reg_addr_i     (addr),
    .reg_wdata_i    (wdata),
    .reg_rdata_o    (rdata),
    .timer_strobe_i (tstb),
    .ssi_clk_o      (sclk),
    .ssi_data_i     (sdat)
  );

  // encoder model: next bit on each falling clock
  always @(negedge sclk[0]) if (enc_idx0 >= 0) begin sdat0 = enc_word0[enc_idx0]; enc_idx0--; end
  always @(negedge sclk[1]) if (enc_idx1 >= 0) begin sdat1 = enc_word1[enc_idx1]; enc_idx1--; end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 4'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 4'(a); #1; d = rdata;
  endtask

  task automatic wait_idle(input int ch, input int restart_at,
                           output int falls, output int rises, output int gap);
    int last_rise = -1;
    logic prev = sclk[ch];
    bit ok = 0;
    falls = 0; rises = 0; gap = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      we = (i == restart_at); addr = 4'(GADDR);
      #1;
      if (sclk[ch] !== prev) begin
        if (sclk[ch]) begin rises++; last_rise = i; end
        else falls++;
      end
      prev = sclk[ch];
      if (!rdata[ch]) begin gap = i - last_rise; ok = 1; break; end
    end
    we = 1'b0;
    if (!ok) chk("R5 frame end", 0, 1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    // 65536*500e3/200e6 = 163.84 -> 163
    rd(2, d); chk("R1 ctrl0", d, 32'h00A3_0000);
    rd(6, d); chk("R1 ctrl1", d, 32'h00A3_0000);
    rd(0, d); chk("R1 lo", d, 0);
    rd(5, d); chk("R1 hi", d, 0);
    rd(GADDR, d); chk("R1 busy", d, 0);
    chk("R1 sclk", sclk, 2'b11);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr(6, 32'hFFFF_FFFF); rd(6, d); chk("R2 mask", d, 32'hFFFF_737F);
    wr(6, 32'h1234_0000); rd(6, d); chk("R2 readback", d, 32'h1234_0000);
  endtask

  task automatic t_rate();
    logic [31:0] d;
    int f, r, g;
    wr(6, 0);
    wr(2, 32'h8000_0104);
    enc_word0 = 64'hB; enc_idx0 = 3;
    wr(GADDR, 32'h0);
    chk("R6 high after start", sclk[0], 1);
    rd(GADDR, d); chk("R5 busy bit0", d, 1);
    @(negedge clk); chk("R6 edge1", sclk[0], 1);
    @(negedge clk); chk("R6 fall at edge2", sclk[0], 0);
    @(negedge clk); chk("R6 edge3", sclk[0], 0);
    @(negedge clk); chk("R6 rise at edge4", sclk[0], 1);
    wait_idle(0, -1, f, r, g);
    rd(0, d); chk("R7 4-bit", d, 32'hB);
  endtask

  task automatic t_frame32();
    logic [31:0] d;
    int f, r, g;
    wr(2, 32'h8000_0120);
    enc_word0 = 64'hDEAD_BEEF; enc_idx0 = 31;
    wr(GADDR, 32'h5);
    wait_idle(0, -1, f, r, g);
    chk("R8 falls", f, 32); chk("R8 rises", r, 32);
    chk("R9 quiet time", g, MONO);
    rd(0, d); chk("R7 lo word", d, 32'hDEAD_BEEF);
    rd(1, d); chk("R7 hi word", d, 0);
  endtask

  task automatic t_frame40();
    logic [31:0] d;
    int f, r, g;
    wr(2, 32'h8000_0120 & ~32'h100);
    wr(6, 32'h4000_0128);
    enc_word1 = 64'hA5_1234_5678; enc_idx1 = 39;
    wr(GADDR, 32'h0);
    rd(GADDR, d); chk("R3 only ch1 starts", d, 2);
    wait_idle(1, -1, f, r, g);
    chk("R8 falls 40", f, 40);
    chk("R9 quiet 40", g, MONO);
    rd(4, d); chk("R7 ch1 lo", d, 32'h1234_5678);
    rd(5, d); chk("R7 ch1 hi", d, 32'hA5);
    rd(0, d); chk("R3 ch0 untouched", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    int f, r, g;
    wr(6, 0);
    wr(2, 32'hFFFF_3208);
    enc_word0 = 64'h5A; enc_idx0 = 7;
    wr(GADDR, 0);
    rd(GADDR, d); chk("R3 bit8 clear no start", d, 0);
    @(negedge clk); tstb = 5'b00010;
    @(negedge clk); tstb = 0;
    rd(GADDR, d); chk("R4 other strobe", d, 0);
    @(negedge clk); tstb = 5'b01000;
    @(negedge clk); tstb = 0;
    rd(GADDR, d); chk("R4 selected strobe", d, 1);
    wait_idle(0, -1, f, r, g);
    rd(0, d); chk("R4 timer frame data", d, 32'h5A);
    wr(2, 32'hFFFF_7208);
    @(negedge clk); tstb = 5'b11111;
    @(negedge clk); tstb = 0;
    rd(GADDR, d); chk("R4 select out of range", d, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    int f, r, g;
    wr(2, 32'h8000_0110);
    enc_word0 = 64'hC3A5; enc_idx0 = 15;
    wr(GADDR, 0);
    wait_idle(0, 10, f, r, g);
    chk("R10 falls", f, 16);
    chk("R10 quiet", g, MONO);
    rd(0, d); chk("R10 data", d, 32'hC3A5);
  endtask

  task automatic t_data_ro();
    logic [31:0] d;
    wr(0, 32'h1111_1111); rd(0, d); chk("R11 lo write ignored", d, 32'hC3A5);
    wr(5, 32'h2222_2222); rd(5, d); chk("R11 hi write ignored", d, 32'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_rate();
    t_frame32();
    t_frame40();
    t_timer();
    t_restart();
    t_data_ro();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule